// File: doc/BRIEF.md
# Per-Pixel Colour Source Selector

This block turns a stream of pixel triples into a stream of 24-bit RGB pixels, one per clock. Each input beat carries three values read together from the same pixel position. The first is an 8-bit palette index. The second is a 32-bit true-colour word. The third is a 32-bit control word whose top byte is a per-pixel tag. Each pixel picks its own source from that tag. When the tag holds the direct code, the low 24 bits of the colour word are used as they are. Any other tag sends the index through a 256-entry colour table. The table sits outside the block and is reached through a combinational read port.

A mode input forces every pixel onto the palette path, for frames that carry only indexed data. The result is held in a single output register, so both paths have the same one-cycle latency.

Both streams use valid/ready handshakes. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in that same cycle. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output pixel is frozen and no new input is taken. Upstream must then keep its three words steady.

Top module: `pix_source_sel`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: When `mode_8bit` is low and `in_ctrl[31:24]` equals 8'h03, the accepted pixel leaves as `out_rgb = in_direct[23:0]`, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: When `in_ctrl[31:24]` is any value other than 8'h03, the accepted pixel leaves as the palette entry `pal_rgb` for its index (same channel positions as R2). Near misses such as 8'h02, 8'h04, 8'h83 and 8'h07 also take this path.
- R4: On the direct path, `in_direct[31:24]` has no effect on `out_rgb`.
- R5: When `mode_8bit` is high, every pixel takes the palette path, including pixels whose tag is 8'h03.
- R6: A pixel accepted at clock edge k is presented with `out_valid` high just after edge k, with no extra delay on either path.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_rgb` stays unchanged on the next edge.
- R8: `in_ready` is low exactly while the output holds a pixel that is not being taken. Each accepted pixel appears exactly once, in order, after a stall ends.
- R9: `pal_addr` equals `in_idx` in the same cycle, so the palette entry for the pixel being offered is on `pal_rgb`.
- R10: After an output pixel is taken with no new input accepted on that edge, `out_valid` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_8bit | input | 1 | Forces the palette path for all pixels |
| in_valid | input | 1 | Input pixel triple is present |
| in_ready | output | 1 | Block can take an input pixel this cycle |
| in_idx | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | True-colour word; colour in bits 23:0 |
| in_ctrl | input | 32 | Control word; tag in bits 31:24 |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette entry at `pal_addr` (R 23:16, G 15:8, B 7:0) |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_rgb | output | 24 | Output pixel colour |

## Verification
The bench builds the block with its default parameters: 8-bit channels, an 8-bit index, 32-bit words and a direct tag code of 8'h03. These give the full 256-entry index range and let tags that differ from the code by a single bit be tried against it. The external palette is modelled as a computed function of the address, so every index returns a distinct known colour. Each back-pressure case runs a stall of several cycles with a second pixel waiting, so that lost, repeated or early pixels show up at the output.

// File: rtl/pix_source_pkg.sv
package pix_source_pkg;

  typedef enum logic {
    SRC_PALETTE = 1'b0,
    SRC_DIRECT  = 1'b1
  } pix_src_e;

  localparam int unsigned NUM_CH = 3;

endpackage

// File: rtl/pix_tag_decode.sv
module pix_tag_decode
  import pix_source_pkg::*;
#(
  parameter int unsigned TAG_W      = 8,
  parameter logic [7:0]  TAG_DIRECT = 8'h03
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             force_palette,
  output pix_src_e         src
);

  localparam logic [TAG_W-1:0] DIRECT_CODE = TAG_W'(TAG_DIRECT);

  // only an exact match selects the true-colour word
  always_comb begin
    if (!force_palette && (tag == DIRECT_CODE)) src = SRC_DIRECT;
    else                                        src = SRC_PALETTE;
  end

endmodule

// File: rtl/pix_color_select.sv
module pix_color_select
  import pix_source_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned RGB_W = CH_W * NUM_CH
) (
  input  pix_src_e         src,
  input  logic [RGB_W-1:0] direct_rgb,
  input  logic [RGB_W-1:0] palette_rgb,
  output logic [RGB_W-1:0] rgb
);

  // per-channel selection, channel 2 = red at the top
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      if (src == SRC_DIRECT) rgb[ch*CH_W +: CH_W] = direct_rgb[ch*CH_W +: CH_W];
      else                   rgb[ch*CH_W +: CH_W] = palette_rgb[ch*CH_W +: CH_W];
    end
  end

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (s_ready) begin
      full_q <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (s_ready && s_valid) begin
      data_q <= s_data;
    end
  end

endmodule

// File: rtl/pix_source_sel.sv
module pix_source_sel
  import pix_source_pkg::*;
#(
  parameter int unsigned CH_W       = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned TAG_W      = 8,
  parameter logic [7:0]  TAG_DIRECT = 8'h03,
  localparam int unsigned RGB_W     = CH_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_8bit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [WORD_W-1:0] in_direct,
  input  logic [WORD_W-1:0] in_ctrl,
  output logic [IDX_W-1:0]  pal_addr,
  input  logic [RGB_W-1:0]  pal_rgb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb
);

  pix_src_e         src;
  logic [RGB_W-1:0] sel_rgb;

  // the upper bits of the colour word and the lower control bits carry no meaning here
  logic unused_bits;
  assign unused_bits = ^{in_direct[WORD_W-1:RGB_W], in_ctrl[WORD_W-TAG_W-1:0]};

  assign pal_addr = in_idx;

  pix_tag_decode #(
    .TAG_W      (TAG_W),
    .TAG_DIRECT (TAG_DIRECT)
  ) u_decode (
    .tag           (in_ctrl[WORD_W-1 -: TAG_W]),
    .force_palette (mode_8bit),
    .src           (src)
  );

  pix_color_select #(
    .CH_W (CH_W)
  ) u_select (
    .src         (src),
    .direct_rgb  (in_direct[RGB_W-1:0]),
    .palette_rgb (pal_rgb),
    .rgb         (sel_rgb)
  );

  pix_out_stage #(
    .DATA_W (RGB_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (sel_rgb),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_rgb)
  );

endmodule

// File: rtl/pix_source_sel_chk.sv
module pix_source_sel_chk #(
  parameter int unsigned CH_W       = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned TAG_W      = 8,
  parameter logic [7:0]  TAG_DIRECT = 8'h03,
  localparam int unsigned RGB_W     = CH_W * 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_8bit,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  in_idx,
  input logic [WORD_W-1:0] in_direct,
  input logic [WORD_W-1:0] in_ctrl,
  input logic [IDX_W-1:0]  pal_addr,
  input logic [RGB_W-1:0]  pal_rgb,
  input logic              out_valid,
  input logic              out_ready,
  input logic [RGB_W-1:0]  out_rgb
);

  localparam logic [TAG_W-1:0] CODE = TAG_W'(TAG_DIRECT);

  logic take;
  logic is_direct;
  assign take      = in_valid && in_ready;
  assign is_direct = !mode_8bit && (in_ctrl[WORD_W-1 -: TAG_W] == CODE);

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_direct |=> out_rgb == $past(in_direct[RGB_W-1:0]));

  assert_palette_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !is_direct |=> out_rgb == $past(pal_rgb));

  assert_force_palette_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode_8bit |=> out_rgb == $past(pal_rgb));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_valid && out_ready |=> !out_valid);

endmodule

bind pix_source_sel pix_source_sel_chk #(
  .CH_W       (CH_W),
  .IDX_W      (IDX_W),
  .WORD_W     (WORD_W),
  .TAG_W      (TAG_W),
  .TAG_DIRECT (TAG_DIRECT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_8bit (mode_8bit),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_idx    (in_idx),
  .in_direct (in_direct),
  .in_ctrl   (in_ctrl),
  .pal_addr  (pal_addr),
  .pal_rgb   (pal_rgb),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rgb   (out_rgb)
);

// File: tb/pix_source_sel_tb.sv
module pix_source_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_8bit;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_idx;
  logic [31:0] in_direct;
  logic [31:0] in_ctrl;
  logic [7:0]  pal_addr;
  logic [23:0] pal_rgb;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_rgb;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [23:0] pal_of(input logic [7:0] a);
    return {a ^ 8'h5A, a + 8'd17, ~a};
  endfunction

  always_comb pal_rgb = pal_of(pal_addr);

  pix_source_sel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_8bit (mode_8bit),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_idx    (in_idx),
    .in_direct (in_direct),
    .in_ctrl   (in_ctrl),
    .pal_addr  (pal_addr),
    .pal_rgb   (pal_rgb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offer one pixel with out_ready high; check address, latency and colour
  task automatic send(input string req, input logic [7:0] idx, input logic [31:0] dw,
                      input logic [31:0] cw, input logic [23:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_idx = idx; in_direct = dw; in_ctrl = cw; out_ready = 1'b1;
    #1 check("R9 address", {24'h0, pal_addr}, {24'h0, idx});
    @(posedge clk);
    #1 check("R6 valid after one edge", {31'h0, out_valid}, 32'h1);
    check(req, {8'h0, out_rgb}, {8'h0, exp});
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1 check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_direct();
    mode_8bit = 1'b0;
    send("R2 direct", 8'h10, 32'h00A1B2C3, 32'h03000000, 24'hA1B2C3);
    send("R2 direct low bits of ctrl", 8'h11, 32'h00123456, 32'h03FFFFFF, 24'h123456);
    send("R4 top byte ignored", 8'h12, 32'hFF123456, 32'h03000000, 24'h123456);
    send("R4 top byte ignored", 8'h13, 32'h5A000000, 32'h03000001, 24'h000000);
    go_idle();
  endtask

  task automatic t_palette();
    mode_8bit = 1'b0;
    send("R3 tag 00", 8'h00, 32'h00ABCDEF, 32'h00000000, pal_of(8'h00));
    send("R3 tag 02", 8'h44, 32'h00ABCDEF, 32'h02000000, pal_of(8'h44));
    send("R3 tag 04", 8'h80, 32'h00ABCDEF, 32'h04000000, pal_of(8'h80));
    send("R3 tag 83", 8'hFE, 32'h00ABCDEF, 32'h83000000, pal_of(8'hFE));
    send("R3 tag 07", 8'h01, 32'h00ABCDEF, 32'h07000000, pal_of(8'h01));
    send("R3 tag FF idx FF", 8'hFF, 32'h00ABCDEF, 32'hFF030303, pal_of(8'hFF));
    go_idle();
  endtask

  task automatic t_mode8();
    mode_8bit = 1'b1;
    send("R5 forced palette", 8'h21, 32'h00FEDCBA, 32'h03000000, pal_of(8'h21));
    send("R5 forced palette", 8'h7F, 32'hFF000000, 32'h03FFFFFF, pal_of(8'h7F));
    mode_8bit = 1'b0;
    send("R5 mode off again direct", 8'h7F, 32'h00010203, 32'h03000000, 24'h010203);
    go_idle();
  endtask

  task automatic t_bubble();
    send("R2 before bubble", 8'h05, 32'h00C0FFEE, 32'h03000000, 24'hC0FFEE);
    go_idle();
    @(posedge clk);
    #1 check("R10 out_valid drops", {31'h0, out_valid}, 32'h0);
    check("R10 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_stall();
    mode_8bit = 1'b0;
    send("R2 pixel A", 8'h09, 32'h00AAAA01, 32'h03000000, 24'hAAAA01);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_idx = 8'h33; in_direct = 32'h00BBBB02; in_ctrl = 32'h01000000;
    #1 check("R8 in_ready low in stall", {31'h0, in_ready}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1 check("R7 valid held", {31'h0, out_valid}, 32'h1);
      check("R7 data held", {8'h0, out_rgb}, 32'h00AAAA01);
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1 check("R8 in_ready when drained", {31'h0, in_ready}, 32'h1);
    @(posedge clk);
    #1 check("R8 pixel B after stall", {8'h0, out_rgb}, {8'h0, pal_of(8'h33)});
    check("R8 valid B", {31'h0, out_valid}, 32'h1);
    go_idle();
    @(posedge clk);
    #1 check("R8 B emitted once", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; mode_8bit = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_idx = '0; in_direct = '0; in_ctrl = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_direct();
    t_palette();
    t_mode8();
    t_bubble();
    t_stall();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule